// File: doc/BRIEF.md
# Power-fail supervisor with reset timer

This block is a synchronous supervisor for a battery-backed memory subsystem. It receives four supply comparator flags from analog circuitry: supply above the trip point, supply above the switch point, supply below the battery voltage, and supply above the full-function level. Each flag passes through a synchroniser. From the synchronised flags the block drives five outputs: a write-protect signal for the memory, a select that routes the memory to the backup battery, an active-low reset to the host processor, a flag showing that the backup battery is armed, and an enable for the battery charger.

On power-up, write-protect is released after a short recovery interval. The host reset is released only after a longer timeout, so the memory is ready before software runs. On power-down, reset is latched low. A brief rise back above the trip point does not release it. The latch clears when the supply drops below the battery voltage, or when it comes back above the full-function level. The backup battery stays disconnected from reset until the supply first reaches the trip point. This keeps the battery from draining while the part is stored.

Top module: `pfs_supervisor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `reset_n_o` is 0, `protect_o` is 1, `charge_enable_o` is 0, `use_battery_o` is 0 and `battery_enabled_o` is 0.
- R2: Each comparator input passes through a two-flop synchroniser. A level driven before clock edge k shows at the outputs just after edge k+1.
- R3: `protect_o` is 1 whenever the synchronised trip flag is 0. After the flag rises, `protect_o` falls RECOVERY_CYCLES edges later.
- R4: `reset_n_o` is 0 whenever the synchronised trip flag is 0. After the flag rises with no power-down hold pending, `reset_n_o` rises RESET_CYCLES edges later.
- R5: RESET_CYCLES exceeds RECOVERY_CYCLES, so `reset_n_o` is never 1 while `protect_o` is 1.
- R6: A fall of the synchronised trip flag sets a hold. While the hold is set, `reset_n_o` stays 0 and the reset timer is held reloaded. The hold clears on a synchronised below-battery flag or a synchronised full-function flag. If a set and a clear occur in the same cycle, the clear takes precedence.
- R7: `battery_enabled_o` is 0 from reset until the synchronised trip flag is first 1. After that it stays 1 until the next `rst`.
- R8: `use_battery_o` is 1 exactly when `battery_enabled_o` is 1 and the synchronised switch-point flag is 0.
- R9: `charge_enable_o` equals the synchronised trip flag.
- R10: Any drop of the synchronised trip flag reloads both timers. Timing restarts in full at the next rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_above_trip_i | input | 1 | Supply above trip point (asynchronous) |
| cmp_above_switch_i | input | 1 | Supply above battery switch point (asynchronous) |
| cmp_below_batt_i | input | 1 | Supply below battery voltage (asynchronous) |
| cmp_above_full_i | input | 1 | Supply above full-function level (asynchronous) |
| protect_o | output | 1 | Memory write-protect, active high |
| use_battery_o | output | 1 | Route memory supply to battery |
| reset_n_o | output | 1 | Host reset, active low |
| battery_enabled_o | output | 1 | Backup battery armed |
| charge_enable_o | output | 1 | Battery charger enable |

## Verification
Two events can fall in the same cycle: a fall of the trip flag, which sets the power-down hold, and a below-battery flag, which clears it. The bench raises below-battery in the same cycle that it drops the trip flag. The case is judged by what happens on the next rise of the trip flag: the reset timer must start at once rather than wait for a full-function flag. The bench also drops the trip flag in the middle of both timers. It then checks the release cycles for protect and reset after the next rise, comparing every cycle against a behavioural model.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int N_FLAGS = 4;

    // Bit positions inside the packed flag vector
    localparam int IDX_TRIP   = 0;
    localparam int IDX_SWITCH = 1;
    localparam int IDX_BELOW  = 2;
    localparam int IDX_FULL   = 3;

    typedef struct packed {
        logic above_full;
        logic below_batt;
        logic above_switch;
        logic above_trip;
    } supply_flags_t;

    function automatic supply_flags_t unpack_flags(input logic [N_FLAGS-1:0] v);
        supply_flags_t f;
        f.above_trip   = v[IDX_TRIP];
        f.above_switch = v[IDX_SWITCH];
        f.below_batt   = v[IDX_BELOW];
        f.above_full   = v[IDX_FULL];
        return f;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned load);
        return (load < 2) ? 1 : $clog2(load + 1);
    endfunction

endpackage

// File: rtl/pfs_flag_sync.sv
module pfs_flag_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= '0;
                    else     pipe[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= '0;
                    else     pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/pfs_interval_timer.sv
module pfs_interval_timer
    import pfs_pkg::*;
#(
    parameter int LOAD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic done
);
    localparam int CW = cnt_width(LOAD);
    localparam logic [CW-1:0] LOAD_V = CW'(LOAD);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)  cnt <= LOAD_V;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pfs_state_ctrl.sv
module pfs_state_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic trip_ok,
    input  logic below_batt,
    input  logic above_full,
    output logic hold,
    output logic armed
);
    logic trip_q;
    logic trip_fell;
    logic hold_clr;

    assign trip_fell = trip_q && !trip_ok;
    assign hold_clr  = below_batt || above_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_q <= 1'b0;
            hold   <= 1'b0;
            armed  <= 1'b0;
        end else begin
            trip_q <= trip_ok;
            // clear wins over set
            hold   <= (hold || trip_fell) && !hold_clr;
            armed  <= armed || trip_ok;
        end
    end
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
    import pfs_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int RECOVERY_CYCLES = 6,
    parameter int RESET_CYCLES    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_above_trip_i,
    input  logic cmp_above_switch_i,
    input  logic cmp_below_batt_i,
    input  logic cmp_above_full_i,
    output logic protect_o,
    output logic use_battery_o,
    output logic reset_n_o,
    output logic battery_enabled_o,
    output logic charge_enable_o
);
    logic [N_FLAGS-1:0] raw_vec;
    logic [N_FLAGS-1:0] sync_vec;
    supply_flags_t      fl;
    logic               hold;
    logic               armed;
    logic               rec_done;
    logic               rst_done;

    always_comb begin
        raw_vec            = '0;
        raw_vec[IDX_TRIP]   = cmp_above_trip_i;
        raw_vec[IDX_SWITCH] = cmp_above_switch_i;
        raw_vec[IDX_BELOW]  = cmp_below_batt_i;
        raw_vec[IDX_FULL]   = cmp_above_full_i;
    end

    pfs_flag_sync #(.WIDTH(N_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(raw_vec), .sync_o(sync_vec)
    );

    assign fl = unpack_flags(sync_vec);

    pfs_state_ctrl u_state (
        .clk(clk), .rst(rst),
        .trip_ok(fl.above_trip), .below_batt(fl.below_batt), .above_full(fl.above_full),
        .hold(hold), .armed(armed)
    );

    pfs_interval_timer #(.LOAD(RECOVERY_CYCLES)) u_rec_tmr (
        .clk(clk), .rst(rst), .restart(!fl.above_trip), .done(rec_done)
    );

    pfs_interval_timer #(.LOAD(RESET_CYCLES)) u_rst_tmr (
        .clk(clk), .rst(rst), .restart(!fl.above_trip || hold), .done(rst_done)
    );

    assign protect_o         = !(fl.above_trip && rec_done);
    assign reset_n_o         = fl.above_trip && !hold && rst_done;
    assign charge_enable_o   = fl.above_trip;
    assign battery_enabled_o = armed;
    assign use_battery_o     = armed && !fl.above_switch;
endmodule

// File: rtl/pfs_supervisor_chk.sv
module pfs_supervisor_chk (
    input logic clk,
    input logic rst,
    input logic protect_o,
    input logic use_battery_o,
    input logic reset_n_o,
    input logic battery_enabled_o,
    input logic charge_enable_o
);
    assert_reset_needs_supply_R4: assert property (@(posedge clk) disable iff (rst)
        reset_n_o |-> charge_enable_o);

    assert_reset_rise_after_supply_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_n_o) |-> $past(charge_enable_o));

    assert_protect_before_reset_R5: assert property (@(posedge clk) disable iff (rst)
        reset_n_o |-> !protect_o);

    assert_protect_on_drop_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(charge_enable_o) |-> protect_o);

    assert_armed_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        battery_enabled_o |=> battery_enabled_o);

    assert_battery_needs_arm_R8: assert property (@(posedge clk) disable iff (rst)
        use_battery_o |-> battery_enabled_o);
endmodule

bind pfs_supervisor pfs_supervisor_chk u_chk (
    .clk(clk), .rst(rst), .protect_o(protect_o), .use_battery_o(use_battery_o),
    .reset_n_o(reset_n_o), .battery_enabled_o(battery_enabled_o),
    .charge_enable_o(charge_enable_o)
);

// File: tb/tb_pfs_supervisor.sv
`timescale 1ns/1ps
module tb_pfs_supervisor;
    localparam int REC = 6;
    localparam int RST = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trip = 1'b0, sw = 1'b0, below = 1'b0, full = 1'b0;
    logic protect_o, use_battery_o, reset_n_o, battery_enabled_o, charge_enable_o;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    bit m_s1 [4];
    bit m_s2 [4];
    bit m_prev, m_hold, m_armed;
    int m_rec, m_rc;

    always #2.5 clk = ~clk;

    pfs_supervisor #(.SYNC_STAGES(2), .RECOVERY_CYCLES(REC), .RESET_CYCLES(RST)) dut (
        .clk(clk), .rst(rst),
        .cmp_above_trip_i(trip), .cmp_above_switch_i(sw),
        .cmp_below_batt_i(below), .cmp_above_full_i(full),
        .protect_o(protect_o), .use_battery_o(use_battery_o), .reset_n_o(reset_n_o),
        .battery_enabled_o(battery_enabled_o), .charge_enable_o(charge_enable_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    function automatic bit m_protect();  return !(m_s2[0] && m_rec == 0); endfunction
    function automatic bit m_resetn();   return m_s2[0] && !m_hold && m_rc == 0; endfunction

    // one clock: model update at the edge, comparison at the following falling edge
    task automatic tick();
        bit trip_s, below_s, full_s, fell;
        @(posedge clk);
        trip_s = m_s2[0]; below_s = m_s2[2]; full_s = m_s2[3];
        if (rst) begin
            foreach (m_s1[i]) begin m_s1[i] = 0; m_s2[i] = 0; end
            m_prev = 0; m_hold = 0; m_armed = 0; m_rec = REC; m_rc = RST;
        end else begin
            fell = m_prev && !trip_s;
            if (!trip_s) m_rec = REC; else if (m_rec > 0) m_rec--;
            if (!trip_s || m_hold) m_rc = RST; else if (m_rc > 0) m_rc--;
            m_hold  = (m_hold || fell) && !(below_s || full_s);
            m_armed = m_armed || trip_s;
            m_prev  = trip_s;
            foreach (m_s1[i]) m_s2[i] = m_s1[i];
            m_s1[0] = trip; m_s1[1] = sw; m_s1[2] = below; m_s1[3] = full;
        end
        @(negedge clk);
        chk("R3 protect",         protect_o,         m_protect());
        chk("R4/R6 reset_n",      reset_n_o,         m_resetn());
        chk("R9 charge_enable",   charge_enable_o,   m_s2[0]);
        chk("R7 battery_enabled", battery_enabled_o, m_armed);
        chk("R8 use_battery",     use_battery_o,     m_armed && !m_s2[1]);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic drive(input logic t, input logic s, input logic b, input logic f);
        trip = t; sw = s; below = b; full = f;
    endtask

    initial begin : watchdog
        #(5ns * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset values
        drive(1, 1, 0, 1);
        run(3);
        chk("R1 reset_n",   reset_n_o, 1'b0);
        chk("R1 protect",   protect_o, 1'b1);
        chk("R1 armed",     battery_enabled_o, 1'b0);
        rst = 1'b0;
        drive(0, 0, 1, 0);
        run(4);
        chk("R1 use_battery unarmed", use_battery_o, 1'b0);

        // R2: two-flop latency on the trip flag
        drive(1, 1, 0, 1);
        tick();
        chk("R2 one edge", charge_enable_o, 1'b0);
        tick();
        chk("R2 two edges", charge_enable_o, 1'b1);
        // R3/R4/R5/R7: first power-up, protect releases before reset
        run(RST + 4);
        chk("R4 released", reset_n_o, 1'b1);
        chk("R7 armed", battery_enabled_o, 1'b1);

        // R10: drop mid-timers and rise again
        drive(0, 1, 0, 0);
        run(4);
        drive(1, 1, 0, 1);
        run(REC - 2);
        drive(0, 1, 0, 0);
        run(2);
        drive(1, 1, 0, 1);
        run(RST + 4);

        // R6: brown-out, back above trip without full flag: reset held
        drive(0, 1, 0, 0);
        run(4);
        drive(1, 1, 0, 0);
        run(RST + 6);
        chk("R6 hold keeps reset", reset_n_o, 1'b0);
        drive(1, 1, 0, 1);            // full-function clears hold
        run(RST + 4);
        chk("R6 release after full", reset_n_o, 1'b1);

        // R8: power-down to battery, switch point lost
        drive(0, 1, 0, 0);
        run(3);
        drive(0, 0, 0, 0);
        run(3);
        chk("R8 on battery", use_battery_o, 1'b1);
        drive(0, 0, 1, 0);            // below battery clears hold
        run(4);
        drive(1, 1, 0, 0);            // no full flag needed now
        run(RST + 4);
        chk("R6 hold cleared by battery", reset_n_o, 1'b1);

        // R6: set and clear collide in one cycle
        drive(0, 1, 1, 0);
        run(3);
        drive(1, 1, 0, 0);
        run(RST + 4);
        chk("R6 clear wins", reset_n_o, 1'b1);

        // R7: armed stays through reset-free power loss; cleared by rst
        drive(0, 0, 1, 0);
        run(5);
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        run(3);
        chk("R7 cleared by rst", battery_enabled_o, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule